// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bank with External Bus Multiplexing

This block models the parallel I/O of a small 8-bit controller. It has four 8-bit ports. Every line has its own output latch. A latch bit of 0 turns on a pull-down on that line. A latch bit of 1 leaves the line to a weak pull-up, so an outside source can still pull it low. The CPU writes the latches, and it can read either the levels sensed on the pins or the latch contents. To read an outside input, software first writes 1 to that line so that the pull-down is off.

When the CPU starts an external memory access, a small bus sequencer takes over two of the ports. The high-address port shows the upper address byte through a 2:1 selector for the whole access. The low-address port is shared over time: it first shows the low address byte, with an address-latch strobe. It then either drives write data or lets the lines go so that read data can be captured from the pins. The sequencer's states are BUS_IDLE, BUS_ADDR, BUS_DATA and BUS_DONE. Its transitions are:
- BUS_IDLE→BUS_ADDR on an accepted request.
- BUS_ADDR→BUS_DATA unconditionally.
- BUS_DATA→BUS_DONE unconditionally, capturing read data on this edge.
- BUS_DONE→BUS_IDLE unconditionally.
- BUS_IDLE stays in BUS_IDLE when there is no request.

A separate combinational path decides for each instruction fetch whether it goes to internal or external program memory. The decision uses the program counter and an external-access pin.

Top module: `qport_bus_mux`

## Requirements
- R1: After reset every latch reads back 0xFF, every pull-down enable is 0, and both the address-latch strobe and the done pulse are low.
- R2: In the cycle after a CPU write to port p (select value p, with port 0 on bits 7:0 up to port 3 on bits 31:24 of the pin vectors), `pd_en` for that port equals the bitwise inverse of the written byte, provided the bus does not own the port.
- R3: A pin read (`cpu_rd`=1, `cpu_rd_latch`=0) returns the selected port's 8 bits of `pin_in` in `rd_data` one cycle later.
- R4: A latch read (`cpu_rd`=1, `cpu_rd_latch`=1) returns the selected latch one cycle later, whatever the pin levels are.
- R5: One cycle after a request is accepted in BUS_IDLE, `bus_ale` is 1 for exactly one cycle. During that cycle port 0 `pd_en` is the inverse of address bits 7:0, and port 2 `pd_en` is the inverse of address bits 15:8.
- R6: In the following cycle (BUS_DATA) of a write, port 0 `pd_en` is the inverse of the write data, port 2 still shows the inverse of the high address byte, and `bus_ale` is 0.
- R7: In BUS_DATA of a read, port 0 `pd_en` is all 0. In the next cycle `bus_done` pulses for one cycle, and `bus_rdata` holds the port 0 pin levels sampled at the end of BUS_DATA.
- R8: In BUS_DONE and afterwards, ports 0 and 2 return to driving from their latches. A bus access does not change any latch.
- R9: Ports 1 and 3 are never affected by bus accesses.
- R10: A request raised while the sequencer is not in BUS_IDLE is ignored. It neither restarts nor extends the current access.
- R11: With `ea_pin` low, `fetch_ext` is 1 for every program counter value.
- R12: With `ea_pin` high, `fetch_ext` is 1 exactly when `pc` is at least IROM_BYTES (4096 by default).
- R13: A CPU write to port 0 during an access updates that latch at once, as a latch read shows. The pins show the new value only from BUS_DONE on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Latch write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_rd_latch | input | 1 | Read source: 1 latch, 0 pins |
| cpu_sel | input | 2 | Port select for read and write |
| cpu_wdata | input | 8 | Latch write data |
| rd_data | output | 8 | Registered read result |
| pin_in | input | 32 | Sensed pin levels, port p at bits 8p+7:8p |
| pd_en | output | 32 | Pull-down enables, same bit layout |
| bus_req | input | 1 | External access request, taken only in BUS_IDLE |
| bus_we | input | 1 | Access direction: 1 write, 0 read |
| bus_addr | input | 16 | Access address |
| bus_wdata | input | 8 | Access write data |
| bus_ale | output | 1 | Address-latch strobe (BUS_ADDR) |
| bus_done | output | 1 | Access-complete pulse (BUS_DONE) |
| bus_rdata | output | 8 | Captured read data |
| pc | input | 16 | Program counter |
| ea_pin | input | 1 | External-access pin |
| fetch_ext | output | 1 | 1 when the fetch goes to external program memory |

## Verification
The bench sweeps every byte value through every latch and pairs each value with a varying outside pin level. A design that swapped the pull-down polarity, or that read pins where it should read latches, fails at once. The sweep of the fetch decision steps across the whole address space and checks the values at IROM_BYTES-1 and IROM_BYTES on both sides. An off-by-one comparison shows up there as a wrong select exactly at the boundary. The bus accesses check every phase on all four ports, and several corner cases are covered:
- A design that leaves port 0 driven during a read captures its own address.
- A design that forgets to hand the ports back leaves the address on the pins.
- A design that accepts a request in mid-access shows the second address.
- A design that lets the bus overwrite a latch, or blocks a CPU write made during an access, returns the wrong value on a later latch read.

// File: rtl/qpb_pkg.sv
package qpb_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_ADDR = 2'd1,
        BUS_DATA = 2'd2,
        BUS_DONE = 2'd3
    } bus_state_t;

endpackage

// File: rtl/qpb_latch_bank.sv
module qpb_latch_bank #(
    parameter int NPORTS = 4,
    parameter int W      = 8,
    parameter int SELW   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [SELW-1:0]       sel,
    input  logic [W-1:0]          wdata,
    output logic [NPORTS*W-1:0]   latch_q
);

    // One register per port; reset releases every line high.
    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                latch_q[i*W +: W] <= '1;
            end else if (wr && (sel == SELW'(i))) begin
                latch_q[i*W +: W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/qpb_bus_fsm.sv
module qpb_bus_fsm
    import qpb_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  lo_pins,
    output logic          ale,
    output logic          done,
    output logic [W-1:0]  rdata,
    output logic          lo_own,
    output logic [W-1:0]  lo_val,
    output logic          hi_own,
    output logic [W-1:0]  hi_val
);

    bus_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [W-1:0]  wdata_q;
    logic          we_q;
    logic [W-1:0]  rdata_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture and read-data sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state_q == BUS_IDLE && req) begin
                addr_q  <= addr;
                wdata_q <= wdata;
                we_q    <= we;
            end
            if (state_q == BUS_DATA && !we_q) begin
                rdata_q <= lo_pins;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req) state_d = BUS_ADDR;
            BUS_ADDR: state_d = BUS_DATA;
            BUS_DATA: state_d = BUS_DONE;
            BUS_DONE: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        ale    = 1'b0;
        done   = 1'b0;
        lo_own = 1'b0;
        lo_val = '1;
        hi_own = 1'b0;
        hi_val = addr_q[W +: W];
        unique case (state_q)
            BUS_IDLE: ;
            BUS_ADDR: begin
                ale    = 1'b1;
                lo_own = 1'b1;
                lo_val = addr_q[W-1:0];
                hi_own = 1'b1;
            end
            BUS_DATA: begin
                lo_own = 1'b1;
                lo_val = we_q ? wdata_q : '1;
                hi_own = 1'b1;
            end
            BUS_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/qpb_pin_drive.sv
module qpb_pin_drive #(
    parameter int NPORTS  = 4,
    parameter int W       = 8,
    parameter int LO_PORT = 0,
    parameter int HI_PORT = 2
) (
    input  logic [NPORTS*W-1:0] latch_q,
    input  logic                lo_own,
    input  logic [W-1:0]        lo_val,
    input  logic                hi_own,
    input  logic [W-1:0]        hi_val,
    output logic [NPORTS*W-1:0] pd_en
);

    // A line value of 1 releases the pull-down; 0 turns it on.
    for (genvar i = 0; i < NPORTS; i++) begin : g_drv
        if (i == LO_PORT) begin : g_lo
            assign pd_en[i*W +: W] = ~(lo_own ? lo_val : latch_q[i*W +: W]);
        end else if (i == HI_PORT) begin : g_hi
            assign pd_en[i*W +: W] = ~(hi_own ? hi_val : latch_q[i*W +: W]);
        end else begin : g_plain
            assign pd_en[i*W +: W] = ~latch_q[i*W +: W];
        end
    end

endmodule

// File: rtl/qpb_fetch_sel.sv
module qpb_fetch_sel #(
    parameter int AW         = 16,
    parameter int IROM_BYTES = 4096
) (
    input  logic [AW-1:0] pc,
    input  logic          ea_pin,
    output logic          fetch_ext
);

    localparam logic [AW:0] LIMIT = (AW+1)'(IROM_BYTES);

    assign fetch_ext = !ea_pin || ({1'b0, pc} >= LIMIT);

endmodule

// File: rtl/qport_bus_mux.sv
module qport_bus_mux #(
    parameter int NPORTS     = 4,
    parameter int W          = 8,
    parameter int AW         = 16,
    parameter int IROM_BYTES = 4096,
    parameter int LO_PORT    = 0,
    parameter int HI_PORT    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_wr,
    input  logic                          cpu_rd,
    input  logic                          cpu_rd_latch,
    input  logic [$clog2(NPORTS)-1:0]     cpu_sel,
    input  logic [W-1:0]                  cpu_wdata,
    output logic [W-1:0]                  rd_data,
    input  logic [NPORTS*W-1:0]           pin_in,
    output logic [NPORTS*W-1:0]           pd_en,
    input  logic                          bus_req,
    input  logic                          bus_we,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [W-1:0]                  bus_wdata,
    output logic                          bus_ale,
    output logic                          bus_done,
    output logic [W-1:0]                  bus_rdata,
    input  logic [AW-1:0]                 pc,
    input  logic                          ea_pin,
    output logic                          fetch_ext
);

    localparam int SELW = $clog2(NPORTS);

    logic [NPORTS*W-1:0] latch_q;
    logic                lo_own, hi_own;
    logic [W-1:0]        lo_val, hi_val;
    logic [W-1:0]        rd_q;

    qpb_latch_bank #(.NPORTS(NPORTS), .W(W), .SELW(SELW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cpu_wr),
        .sel     (cpu_sel),
        .wdata   (cpu_wdata),
        .latch_q (latch_q)
    );

    qpb_bus_fsm #(.W(W), .AW(AW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .lo_pins (pin_in[LO_PORT*W +: W]),
        .ale     (bus_ale),
        .done    (bus_done),
        .rdata   (bus_rdata),
        .lo_own  (lo_own),
        .lo_val  (lo_val),
        .hi_own  (hi_own),
        .hi_val  (hi_val)
    );

    qpb_pin_drive #(.NPORTS(NPORTS), .W(W), .LO_PORT(LO_PORT), .HI_PORT(HI_PORT)) u_drv (
        .latch_q (latch_q),
        .lo_own  (lo_own),
        .lo_val  (lo_val),
        .hi_own  (hi_own),
        .hi_val  (hi_val),
        .pd_en   (pd_en)
    );

    qpb_fetch_sel #(.AW(AW), .IROM_BYTES(IROM_BYTES)) u_fetch (
        .pc        (pc),
        .ea_pin    (ea_pin),
        .fetch_ext (fetch_ext)
    );

    // Registered read path: pins or latch of the selected port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (cpu_rd) begin
            rd_q <= cpu_rd_latch ? latch_q[cpu_sel*W +: W] : pin_in[cpu_sel*W +: W];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/qport_bus_mux_chk.sv
module qport_bus_mux_chk #(
    parameter int NPORTS     = 4,
    parameter int W          = 8,
    parameter int AW         = 16,
    parameter int IROM_BYTES = 4096
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cpu_wr,
    input logic [NPORTS*W-1:0]   pd_en,
    input logic                  bus_ale,
    input logic                  bus_done,
    input logic [AW-1:0]         pc,
    input logic                  ea_pin,
    input logic                  fetch_ext
);

    localparam logic [AW:0] LIMIT = (AW+1)'(IROM_BYTES);

    assert_ale_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);

    assert_ale_to_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> ##2 bus_done);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_done);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |=> !bus_ale);

    assert_side_ports_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_wr) |-> ($stable(pd_en[1*W +: W]) && $stable(pd_en[3*W +: W])));

    assert_ea_low_external_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_pin |-> fetch_ext);

    assert_internal_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_pin && ({1'b0, pc} < LIMIT)) |-> !fetch_ext);

endmodule

bind qport_bus_mux qport_bus_mux_chk #(
    .NPORTS(NPORTS), .W(W), .AW(AW), .IROM_BYTES(IROM_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .pd_en     (pd_en),
    .bus_ale   (bus_ale),
    .bus_done  (bus_done),
    .pc        (pc),
    .ea_pin    (ea_pin),
    .fetch_ext (fetch_ext)
);

// File: tb/tb_qport_bus_mux.sv
`timescale 1ns/1ps
module tb_qport_bus_mux;

    localparam int IROM = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_rd_latch = 1'b0;
    logic [1:0]  cpu_sel = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  rd_data;
    logic [31:0] pin_in, pd_en;
    logic [31:0] ext_lvl = '1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_ale, bus_done;
    logic [7:0]  bus_rdata;
    logic [15:0] pc = '0;
    logic        ea_pin = 1'b1;
    logic        fetch_ext;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    // Wired-AND pin model: a line is low if the design or the outside pulls it low
    assign pin_in = ~pd_en & ext_lvl;

    qport_bus_mux dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_rd_latch(cpu_rd_latch), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .rd_data(rd_data), .pin_in(pin_in), .pd_en(pd_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ale(bus_ale), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .pc(pc), .ea_pin(ea_pin), .fetch_ext(fetch_ext)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_latch(input int p, input logic [7:0] v);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = 2'(p); cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_port(input int p, input logic from_latch, output logic [7:0] v);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_sel = 2'(p); cpu_rd_latch = from_latch;
        @(negedge clk);
        cpu_rd = 1'b0;
        v = rd_data;
    endtask

    task automatic check_sides(input string req);
        chk(req, {24'd0, pd_en[15:8]},  {24'd0, ~8'h3C});
        chk(req, {24'd0, pd_en[31:24]}, {24'd0, ~8'hA5});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pd_en", pd_en, 32'd0);
        chk("R1 ale", {31'd0, bus_ale}, 32'd0);
        chk("R1 done", {31'd0, bus_done}, 32'd0);
        for (int p = 0; p < 4; p++) begin
            rd_port(p, 1'b1, v);
            chk("R1 latch", {24'd0, v}, 32'hFF);
        end

        // R2/R3/R4 sweep: every byte through every port
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 256; b++) begin
                e = 8'((b * 37 + p * 11) ^ 8'h5A);
                ext_lvl[p*8 +: 8] = e;
                wr_latch(p, 8'(b));
                chk("R2 pull-down", {24'd0, pd_en[p*8 +: 8]}, {24'd0, ~8'(b)});
                rd_port(p, 1'b0, v);
                chk("R3 pin read", {24'd0, v}, {24'd0, 8'(b) & e});
                rd_port(p, 1'b1, v);
                chk("R4 latch read", {24'd0, v}, {24'd0, 8'(b)});
            end
            ext_lvl[p*8 +: 8] = 8'hFF;
        end

        // R11/R12 fetch select sweep
        for (int ea = 0; ea < 2; ea++) begin
            for (int k = 0; k < 263; k++) begin
                int a;
                if (k < 256) a = k * 257;
                else begin
                    case (k)
                        256: a = IROM - 2;
                        257: a = IROM - 1;
                        258: a = IROM;
                        259: a = IROM + 1;
                        260: a = 0;
                        261: a = 65535;
                        default: a = 1;
                    endcase
                end
                @(negedge clk);
                ea_pin = 1'(ea); pc = 16'(a);
                #1;
                if (ea == 0) chk("R11 ea low", {31'd0, fetch_ext}, 32'd1);
                else chk("R12 threshold", {31'd0, fetch_ext}, {31'd0, a >= IROM});
            end
        end
        ea_pin = 1'b1;

        // Bus accesses
        wr_latch(0, 8'h12); wr_latch(1, 8'h3C); wr_latch(2, 8'h34); wr_latch(3, 8'hA5);
        for (int n = 0; n < 16; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            logic        w;
            a = 16'(n * 16'h1357 + 16'h0BEF);
            d = 8'(n * 29 + 3);
            w = n[0];
            @(negedge clk);
            bus_req = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
            ext_lvl[7:0] = w ? 8'hFF : d;
            @(negedge clk);
            bus_req = 1'b0;
            // BUS_ADDR
            chk("R5 ale", {31'd0, bus_ale}, 32'd1);
            chk("R5 low addr", {24'd0, pd_en[7:0]}, {24'd0, ~a[7:0]});
            chk("R5 high addr", {24'd0, pd_en[23:16]}, {24'd0, ~a[15:8]});
            check_sides("R9 addr phase");
            @(negedge clk);
            // BUS_DATA
            if (w) begin
                chk("R6 write data", {24'd0, pd_en[7:0]}, {24'd0, ~d});
                chk("R6 ale low", {31'd0, bus_ale}, 32'd0);
            end else begin
                chk("R7 released", {24'd0, pd_en[7:0]}, 32'd0);
            end
            chk("R6 high addr held", {24'd0, pd_en[23:16]}, {24'd0, ~a[15:8]});
            check_sides("R9 data phase");
            @(negedge clk);
            // BUS_DONE
            chk("R7 done", {31'd0, bus_done}, 32'd1);
            if (!w) chk("R7 rdata", {24'd0, bus_rdata}, {24'd0, d});
            chk("R8 port0 latch", {24'd0, pd_en[7:0]}, {24'd0, ~8'h12});
            chk("R8 port2 latch", {24'd0, pd_en[23:16]}, {24'd0, ~8'h34});
            @(negedge clk);
            chk("R7 done pulse", {31'd0, bus_done}, 32'd0);
        end
        ext_lvl = '1;
        rd_port(0, 1'b1, v);
        chk("R8 latch untouched", {24'd0, v}, 32'h12);
        rd_port(2, 1'b1, v);
        chk("R8 latch untouched", {24'd0, v}, 32'h34);

        // R10: request during an access is ignored; R13 write during access
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'hC3A1; bus_wdata = 8'h66;
        @(negedge clk);
        bus_addr = 16'h5E7F; bus_wdata = 8'h99;
        cpu_wr = 1'b1; cpu_sel = 2'd0; cpu_wdata = 8'h77;
        @(negedge clk);
        bus_req = 1'b0; cpu_wr = 1'b0;
        chk("R10 data kept", {24'd0, pd_en[7:0]}, {24'd0, ~8'h66});
        chk("R10 addr kept", {24'd0, pd_en[23:16]}, {24'd0, ~8'hC3});
        chk("R13 bus owns pins", {24'd0, pd_en[7:0]}, {24'd0, ~8'h66});
        @(negedge clk);
        chk("R10 done", {31'd0, bus_done}, 32'd1);
        chk("R13 latch on pins", {24'd0, pd_en[7:0]}, {24'd0, ~8'h77});
        @(negedge clk);
        chk("R10 no restart ale", {31'd0, bus_ale}, 32'd0);
        @(negedge clk);
        chk("R10 no restart ale", {31'd0, bus_ale}, 32'd0);
        chk("R10 no second done", {31'd0, bus_done}, 32'd0);
        rd_port(0, 1'b1, v);
        chk("R13 latch read", {24'd0, v}, 32'h77);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule